// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block sits between an external device programmer and the on-chip nonvolatile store. The store holds three things: a code array, a data array and a one-byte security-mode register. The programmer supplies a 16-bit address as two byte-wide ports, a 4-bit operation code, a byte of data and an active-low write strobe. Each strobe is synchronised to the core clock. On its falling edge the block samples address, data and operation together and then erases, programs or reads the selected storage. Read results go back on the data lines.

The bidirectional data bus is split at the block edge into an input, an output and an output enable, so the pad can be built outside. Programming uses flash semantics: it can only turn ones into zeros, and only the global erase restores ones. The top 2 KB of the 64 KB code address space holds hidden firmware. It always reads as zero and the programmer cannot alter it. Operation codes that are not assigned do nothing.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After synchronous reset, `busy` is low and `dq_oe` is low.
- R2: An operation is accepted at the second rising clock edge after the first edge that samples `stb_n` low, provided `stb_n` was sampled high just before. `adr_hi`, `adr_lo`, `op_code` and `dq_i` are sampled at that accepting edge.
- R3: Operation code 4'b0000 erases everything. `busy` is high for exactly 2^max(CODE_AW,DATA_AW) cycles (4096 by default), starting after the accepting edge. Afterwards every code byte, every data byte and the security register read 8'hFF.
- R4: Operation code 4'b1010 programs code byte `adr[CODE_AW-1:0]` to old AND `dq_i`. `busy` is high for PROG_CYC cycles (default 4) after the accepting edge.
- R5: Operation code 4'b0010 programs data byte `adr[DATA_AW-1:0]` to old AND `dq_i`. `busy` is high for PROG_CYC cycles.
- R6: Operation code 4'b1011 reads code byte `adr[CODE_AW-1:0]` and 4'b0011 reads data byte `adr[DATA_AW-1:0]`. The code and data arrays are separate spaces. On the edge after acceptance, `dq_oe` goes high with the byte on `dq_o`, and both hold steady until the next strobe.
- R7: A code read at any address from 16'hF800 to 16'hFFFF returns 8'h00. A code program at such an address changes no stored byte, including the byte that shares its low index bits.
- R8: Operation code 4'b1100 programs the security register to old AND `dq_i`. Operation code 4'b1101 reads it back with the timing of R6.
- R9: Every other operation code (4'b0001, 4'b0100–4'b1001, 4'b1110, 4'b1111) changes no storage, leaves `busy` low and leaves `dq_oe` low.
- R10: A strobe whose accepting edge falls while `busy` is high is ignored completely.
- R11: `dq_oe` falls at the first rising edge after the first edge that samples `stb_n` low. This happens before the operation is sampled. `dq_oe` stays low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_lo | input | 8 | Address low byte |
| adr_hi | input | 8 | Address high byte |
| op_code | input | 4 | Operation code |
| stb_n | input | 1 | Active-low write strobe, asynchronous |
| dq_i | input | 8 | Data bus, programmer to block |
| dq_o | output | 8 | Data bus, block to programmer |
| dq_oe | output | 1 | Drive enable for `dq_o` at the pad |
| busy | output | 1 | Program or erase in progress |

## Verification
Every result has a fixed distance from the strobe. With `stb_n` first sampled low at edge k, `dq_oe` drops after edge k+1, and the operation is taken at edge k+2. Read data is driven after edge k+3. `busy` then stays high for PROG_CYC cycles, or for the full sweep length after an erase. The bench's behavioural model advances on every rising edge, keeping a short history of sampled strobe levels and a byte-array image of the store. It is compared with `busy`, `dq_oe` and `dq_o` on every falling edge, so any shift by one cycle is caught. A directed read also checks the release and drive cycles one by one.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  typedef enum logic [3:0] {
    OP_WIPE     = 4'b0000,
    OP_PGM_DATA = 4'b0010,
    OP_RD_DATA  = 4'b0011,
    OP_PGM_CODE = 4'b1010,
    OP_RD_CODE  = 4'b1011,
    OP_PGM_LOCK = 4'b1100,
    OP_RD_LOCK  = 4'b1101
  } op_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  function automatic logic op_is_read(input logic [3:0] c);
    return (c == OP_RD_CODE) || (c == OP_RD_DATA) || (c == OP_RD_LOCK);
  endfunction

  function automatic logic op_is_long(input logic [3:0] c);
    return (c == OP_WIPE) || (c == OP_PGM_CODE) || (c == OP_PGM_DATA) ||
           (c == OP_PGM_LOCK);
  endfunction

endpackage

// File: rtl/pfp_strobe_sync.sv
module pfp_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic lead_fall,
  output logic fall
);

  // sh[0] is the newest sample of the strobe
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= 3'b111;
    else     sh <= {sh[1:0], strobe_n};
  end

  // early pulse one cycle before the acceptance pulse
  assign lead_fall = sh[1] & ~sh[0];
  assign fall      = sh[2] & ~sh[1];

endmodule

// File: rtl/pfp_sram.sv
module pfp_sram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pfp_op_timer.sv
module pfp_op_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] last,
  output logic          busy,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      last_q <= last;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == last_q) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import pfp_pkg::*;
#(
  parameter int          CODE_AW  = 12,
  parameter int          DATA_AW  = 10,
  parameter int          PROG_CYC = 4,
  parameter logic [15:0] RSV_BASE = 16'hF800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] adr_lo,
  input  logic [7:0] adr_hi,
  input  logic [3:0] op_code,
  input  logic       stb_n,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic       busy
);

  localparam int SWEEP_AW  = (CODE_AW > DATA_AW) ? CODE_AW : DATA_AW;
  localparam int SWEEP_LEN = 1 << SWEEP_AW;
  localparam int PG_W      = $clog2(PROG_CYC + 1);
  localparam int CNT_W     = ((SWEEP_AW > PG_W) ? SWEEP_AW : PG_W) + 1;
  localparam int MAX_RUN   = (SWEEP_LEN > PROG_CYC) ? SWEEP_LEN : PROG_CYC;

  logic              lead_fall, fall, accept, start;
  logic [15:0]       adr_bus, adr_q;
  logic [3:0]        op_q;
  logic [7:0]        dq_q;
  logic              rd_pend_q, wr_pend_q;
  logic [CNT_W-1:0]  cnt, last_sel;
  logic              wipe_run, hidden;
  logic              code_we, data_we;
  logic [CODE_AW-1:0] code_wa;
  logic [DATA_AW-1:0] data_wa;
  logic [7:0]        code_wd, data_wd, code_rd, data_rd;
  logic [7:0]        lock_q, rd_mux, dout_q;
  logic              oe_q;

  assign adr_bus = {adr_hi, adr_lo};

  pfp_strobe_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .strobe_n  (stb_n),
    .lead_fall (lead_fall),
    .fall      (fall)
  );

  assign accept   = fall & ~busy;
  assign start    = accept & op_is_long(op_code);
  assign last_sel = (op_code == OP_WIPE) ? CNT_W'(SWEEP_LEN - 1)
                                         : CNT_W'(PROG_CYC - 1);

  pfp_op_timer #(.CW(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .last  (last_sel),
    .busy  (busy),
    .cnt   (cnt)
  );

  assign hidden   = (adr_q >= RSV_BASE);
  assign wipe_run = busy && (op_q == OP_WIPE);

  // write side: erase sweep has the port while busy, else read-modify-write
  always_comb begin
    code_we = wipe_run || (wr_pend_q && (op_q == OP_PGM_CODE) && !hidden);
    data_we = wipe_run || (wr_pend_q && (op_q == OP_PGM_DATA));
    code_wa = wipe_run ? cnt[CODE_AW-1:0] : adr_q[CODE_AW-1:0];
    data_wa = wipe_run ? cnt[DATA_AW-1:0] : adr_q[DATA_AW-1:0];
    code_wd = wipe_run ? BLANK_BYTE : (code_rd & dq_q);
    data_wd = wipe_run ? BLANK_BYTE : (data_rd & dq_q);
  end

  pfp_sram #(.AW(CODE_AW), .DW(8)) u_code (
    .clk   (clk),
    .we    (code_we),
    .waddr (code_wa),
    .wdata (code_wd),
    .raddr (adr_bus[CODE_AW-1:0]),
    .rdata (code_rd)
  );

  pfp_sram #(.AW(DATA_AW), .DW(8)) u_data (
    .clk   (clk),
    .we    (data_we),
    .waddr (data_wa),
    .wdata (data_wd),
    .raddr (adr_bus[DATA_AW-1:0]),
    .rdata (data_rd)
  );

  always_comb begin
    case (op_q)
      OP_RD_CODE: rd_mux = hidden ? 8'h00 : code_rd;
      OP_RD_DATA: rd_mux = data_rd;
      OP_RD_LOCK: rd_mux = lock_q;
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= 4'b1111;
      adr_q     <= '0;
      dq_q      <= '0;
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
      oe_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      if (accept) begin
        op_q  <= op_code;
        adr_q <= adr_bus;
        dq_q  <= dq_i;
      end
      rd_pend_q <= accept && op_is_read(op_code);
      wr_pend_q <= accept && op_is_long(op_code) && (op_code != OP_WIPE);
      if (rd_pend_q) begin
        oe_q   <= 1'b1;
        dout_q <= rd_mux;
      end
      if (lead_fall) oe_q <= 1'b0;
    end
  end

  // security register: nonvolatile, so no reset
  always_ff @(posedge clk) begin
    if (wipe_run && (cnt == '0))
      lock_q <= BLANK_BYTE;
    else if (wr_pend_q && (op_q == OP_PGM_LOCK))
      lock_q <= lock_q & dq_q;
  end

  assign dq_o  = dout_q;
  assign dq_oe = oe_q;

endmodule

// File: rtl/pfp_checker.sv
module pfp_checker #(
  parameter int          MAX_RUN  = 4096,
  parameter logic [15:0] RSV_BASE = 16'hF800
) (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op_code,
  input logic        busy,
  input logic        dq_oe,
  input logic [7:0]  dq_o,
  input logic        rd_pend,
  input logic [3:0]  op_q,
  input logic [15:0] adr_q
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  AST_BUSY_ONLY_LONG_OPS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(op_code) == 4'b0000 || $past(op_code) == 4'b1010 ||
                     $past(op_code) == 4'b0010 || $past(op_code) == 4'b1100)); // R9

  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(rd_pend)); // R6

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o)); // R6

  AST_NO_DRIVE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dq_oe); // R11

  AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && op_q == 4'b1011 && adr_q >= RSV_BASE) |-> dq_o == 8'h00); // R7

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < MAX_RUN); // R3

endmodule

bind flash_pgm_ctrl pfp_checker #(.MAX_RUN(MAX_RUN), .RSV_BASE(RSV_BASE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .busy    (busy),
  .dq_oe   (dq_oe),
  .dq_o    (dq_o),
  .rd_pend (rd_pend_q),
  .op_q    (op_q),
  .adr_q   (adr_q)
);

// File: tb/test_flash_pgm_ctrl.sv
`timescale 1ns/1ps
module test_flash_pgm_ctrl;

  localparam int CODE_DEPTH = 4096;
  localparam int DATA_DEPTH = 1024;
  localparam int SWEEP      = 4096;
  localparam int PGM_LEN    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] adr_lo = 8'h00, adr_hi = 8'h00, dq_i = 8'h00;
  logic [3:0] op_code = 4'b1111;
  logic       stb_n = 1'b1;
  logic [7:0] dq_o;
  logic       dq_oe, busy;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_pgm_ctrl i_flash_pgm_ctrl (
    .clk(clk), .rst(rst), .adr_lo(adr_lo), .adr_hi(adr_hi), .op_code(op_code),
    .stb_n(stb_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_code [CODE_DEPTH];
  logic [7:0] m_data [DATA_DEPTH];
  logic [7:0] m_lock;
  bit   hist[$];
  bit   m_busy = 0, m_oe = 0, m_pend = 0;
  int   m_left = 0;
  logic [7:0] m_dout = 8'h00, m_pval = 8'h00;
  string m_btag = "R1", m_rtag = "R6", cur_tag = "R6";

  task automatic model_accept();
    int a;
    a = {adr_hi, adr_lo};
    case (op_code)
      4'b0000: begin
        foreach (m_code[i]) m_code[i] = 8'hFF;
        foreach (m_data[i]) m_data[i] = 8'hFF;
        m_lock = 8'hFF; m_busy = 1; m_left = SWEEP; m_btag = "R3";
      end
      4'b1010: begin
        if (a < 16'hF800) m_code[a % CODE_DEPTH] &= dq_i;
        m_busy = 1; m_left = PGM_LEN; m_btag = "R4";
      end
      4'b0010: begin
        m_data[a % DATA_DEPTH] &= dq_i;
        m_busy = 1; m_left = PGM_LEN; m_btag = "R5";
      end
      4'b1100: begin
        m_lock &= dq_i; m_busy = 1; m_left = PGM_LEN; m_btag = "R8";
      end
      4'b1011: begin
        m_pend = 1; m_pval = (a >= 16'hF800) ? 8'h00 : m_code[a % CODE_DEPTH];
        m_rtag = cur_tag; m_btag = "R6";
      end
      4'b0011: begin
        m_pend = 1; m_pval = m_data[a % DATA_DEPTH]; m_rtag = cur_tag; m_btag = "R6";
      end
      4'b1101: begin
        m_pend = 1; m_pval = m_lock; m_rtag = cur_tag; m_btag = "R8";
      end
      default: m_btag = "R9";
    endcase
  endtask

  always @(posedge clk) begin
    bit f1, f, was_busy;
    if (rst) begin
      hist.delete();
      repeat (3) hist.push_front(1'b1);
      m_busy = 0; m_left = 0; m_oe = 0; m_pend = 0;
    end else begin
      f1 = hist[1] && !hist[0];
      f  = hist[2] && !hist[1];
      hist.push_front(stb_n);
      void'(hist.pop_back());
      was_busy = m_busy;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
      end
      if (m_pend) begin m_oe = 1; m_dout = m_pval; m_pend = 0; end
      if (f1) m_oe = 0;
      if (f) begin
        if (was_busy) m_btag = "R10";
        else model_accept();
      end
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(busy === m_busy, m_btag, busy, m_busy);
      chk(dq_oe === m_oe, "R11", dq_oe, m_oe);
      if (m_oe) chk(dq_o === m_dout, m_rtag, dq_o, m_dout);
    end
  end

  // ---------------- stimulus ----------------
  task automatic strobe(input logic [3:0] c, input logic [15:0] a,
                        input logic [7:0] d, input bit wait_idle);
    @(negedge clk);
    op_code = c; adr_hi = a[15:8]; adr_lo = a[7:0]; dq_i = d; stb_n = 1'b0;
    repeat (5) @(negedge clk);
    stb_n = 1'b1;
    repeat (4) @(negedge clk);
    if (wait_idle) begin
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic rd(input logic [3:0] c, input logic [15:0] a, input string tag);
    cur_tag = tag;
    strobe(c, a, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R1", busy, 0);
    chk(dq_oe === 1'b0, "R1", dq_oe, 0);

    // R3: full erase, spot reads at both ends of each array
    strobe(4'b0000, 16'h0000, 8'h00, 1'b1);
    rd(4'b1011, 16'h0000, "R3");
    rd(4'b1011, 16'h0FFF, "R3");
    rd(4'b0011, 16'h0000, "R3");
    rd(4'b0011, 16'h03FF, "R3");
    rd(4'b1101, 16'h0000, "R3");

    // R4: program code, bits can only clear
    strobe(4'b1010, 16'h0123, 8'hA5, 1'b1);
    rd(4'b1011, 16'h0123, "R4");
    strobe(4'b1010, 16'h0123, 8'h3C, 1'b1);
    rd(4'b1011, 16'h0123, "R4");

    // R5: program data, neighbour untouched
    strobe(4'b0010, 16'h0045, 8'h5A, 1'b1);
    rd(4'b0011, 16'h0045, "R5");
    rd(4'b0011, 16'h0145, "R5");

    // R6: code and data are separate spaces
    rd(4'b1011, 16'h0045, "R6");
    rd(4'b0011, 16'h0123, "R6");

    // R7: hidden region reads zero, programming there is blocked
    rd(4'b1011, 16'hF800, "R7");
    rd(4'b1011, 16'hFFFF, "R7");
    strobe(4'b1010, 16'hF900, 8'h00, 1'b1);
    rd(4'b1011, 16'h0900, "R7");

    // R8: security register program and verify
    strobe(4'b1100, 16'h0000, 8'h96, 1'b1);
    rd(4'b1101, 16'h0000, "R8");
    strobe(4'b1100, 16'h0000, 8'hF0, 1'b1);
    rd(4'b1101, 16'h0000, "R8");

    // R9: every unassigned code is a no-op
    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 2, 3, 10, 11, 12, 13})) begin
        strobe(4'(c), 16'h0123, 8'h00, 1'b1);
        chk(busy === 1'b0 && dq_oe === 1'b0, "R9", {busy, dq_oe}, 0);
      end
    end
    rd(4'b1011, 16'h0123, "R9");
    rd(4'b0011, 16'h0045, "R9");
    rd(4'b1101, 16'h0000, "R9");

    // R2 / R11: cycle-exact release and drive around a read (bus driven now)
    @(negedge clk);
    chk(dq_oe === 1'b1, "R11", dq_oe, 1);
    op_code = 4'b1011; adr_hi = 8'h01; adr_lo = 8'h23; stb_n = 1'b0;
    @(negedge clk);  // after first low sample
    chk(dq_oe === 1'b1, "R11", dq_oe, 1);
    @(negedge clk);  // released
    chk(dq_oe === 1'b0, "R11", dq_oe, 0);
    @(negedge clk);  // accepted, data not yet out
    chk(dq_oe === 1'b0, "R2", dq_oe, 0);
    @(negedge clk);  // data driven
    chk(dq_oe === 1'b1, "R2", dq_oe, 1);
    chk(dq_o === 8'h24, "R2", dq_o, 8'h24);
    @(negedge clk);
    stb_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: strobe during an erase is ignored; erase clears everything (R3)
    strobe(4'b0000, 16'h0000, 8'h00, 1'b0);
    strobe(4'b1010, 16'h0010, 8'h00, 1'b0);
    chk(busy === 1'b1, "R10", busy, 1);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(4'b1011, 16'h0010, "R10");
    rd(4'b1011, 16'h0123, "R3");
    rd(4'b1101, 16'h0000, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule